// File: doc/BRIEF.md
# Preload Timer/Event Counter

An up-counter that runs from a programmable start value. Software writes the start value into a preload register. The counter climbs from that value, and when it steps past all-ones it reloads the preload value and keeps running. Each wrap produces a one-cycle overflow strobe. The wrap can also latch an interrupt request that stays high until it is acknowledged.

Three counting sources are available:
- Timer mode counts the internal clock, divided by a power-of-two prescaler.
- Event mode counts one chosen edge of an external pin.
- Pulse-width mode counts prescaled internal clock ticks, but only while the external pin sits at a chosen level.

The external pin passes through a two-flop synchronizer before it is used. A count read or a preload write inhibits counting in that cycle.

Top module: `preload_timer`

## Requirements
- R1: After reset the count, the overflow strobe and the interrupt request are all 0.
- R2: A preload write while the counter is not running loads both the preload register and the count. While running, it updates only the preload register, and the count is unchanged in that cycle.
- R3: Control field ctrl[1:0] selects the mode. Value 2'b10 is timer mode, which adds one per prescaler tick. The prescale select ctrl[7:5]=p gives one tick every 2^p clocks, counted from the last control write.
- R4: An increment from all-ones reloads the count with the preload value and raises `ovf` for exactly one cycle, in the cycle where the reloaded value is visible.
- R5: `irq` is set together with an overflow only when ctrl[4]=1. Once set, it stays high until `irq_ack` clears it, and a new overflow takes precedence over the acknowledge.
- R6: The count freezes without being cleared when the enable bit ctrl[3] is 0 or the mode is 2'b00.
- R7: Mode 2'b01 counts edges of `ext_in`: rising edges when ctrl[2]=0, falling edges when ctrl[2]=1. The change shows on `count` at the third rising clock edge after the pin changes.
- R8: Mode 2'b11 counts prescaler ticks while the synchronized pin is high (ctrl[2]=0) or low (ctrl[2]=1). A pulse of N clocks at ps=0 adds N.
- R9: In any cycle where `rd_count` or `wr_preload` is high, no increment takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_preload | input | 1 | Preload register write strobe |
| wdata | input | W | Preload write data |
| wr_ctrl | input | 1 | Control register write strobe |
| ctrl_data | input | 5+PSW | Control data: mode[1:0], polarity[2], enable[3], irq enable[4], prescale[7:5] |
| rd_count | input | 1 | Count read strobe (inhibits counting) |
| count | output | W | Current count |
| ext_in | input | 1 | External event / gate pin (asynchronous) |
| irq_ack | input | 1 | Clears the interrupt request |
| ovf | output | 1 | One-cycle overflow strobe |
| irq | output | 1 | Latched interrupt request |

## Verification
Two pairs of functions can fall in the same cycle:
- A counting step and a register access. The bench holds `rd_count` high, and separately writes the preload while the counter is running. It then checks that the count stays frozen across those edges and resumes right afterwards.
- A wrap and an interrupt acknowledge. The checker asserts that the interrupt only rises on an enabled overflow. The bench stops the counter before it acknowledges, so that the clear can be judged on its own.

// File: rtl/preload_timer.sv
module preload_timer #(
  parameter int W   = 8,
  parameter int PSW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_preload,
  input  logic [W-1:0]     wdata,
  input  logic             wr_ctrl,
  input  logic [4+PSW:0]   ctrl_data,
  input  logic             rd_count,
  output logic [W-1:0]     count,
  input  logic             ext_in,
  input  logic             irq_ack,
  output logic             ovf,
  output logic             irq
);
  localparam int PCW = (1 << PSW) - 1;

  logic [1:0]     mode;
  logic           pol, en, ien;
  logic [PSW-1:0] ps;
  logic [PCW-1:0] presc;
  logic [W-1:0]   pre, cnt;
  logic           s1, s2, s3;

  logic [PCW-1:0] pmask;
  logic           tick, lvl, lvl_d, edge_ev, run, src, inc, wrap;

  assign pmask   = ~({PCW{1'b1}} << ps);
  assign tick    = (presc & pmask) == pmask;
  assign lvl     = s2 ^ pol;
  assign lvl_d   = s3 ^ pol;
  assign edge_ev = lvl & ~lvl_d;
  assign run     = en && (mode != 2'b00);

  always_comb begin
    case (mode)
      2'b01:   src = edge_ev;
      2'b10:   src = tick;
      2'b11:   src = tick & lvl;
      default: src = 1'b0;
    endcase
  end

  assign inc   = run & src & ~rd_count & ~wr_preload;
  assign wrap  = inc && (cnt == {W{1'b1}});
  assign count = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      presc <= '0;
      {mode, pol, en, ien, ps} <= '0;
      pre <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      irq <= 1'b0;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
      s3 <= s2;
      presc <= wr_ctrl ? '0 : presc + 1'b1;
      if (wr_ctrl) begin
        mode <= ctrl_data[1:0];
        pol  <= ctrl_data[2];
        en   <= ctrl_data[3];
        ien  <= ctrl_data[4];
        ps   <= ctrl_data[4+PSW:5];
      end
      if (wr_preload) pre <= wdata;
      if (wr_preload && !run) cnt <= wdata;
      else if (wrap)          cnt <= pre;
      else if (inc)           cnt <= cnt + 1'b1;
      ovf <= wrap;
      if (wrap && ien)  irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end
endmodule

module preload_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         ien,
  input logic         rd_count,
  input logic         wr_preload,
  input logic [W-1:0] count,
  input logic [W-1:0] pre,
  input logic         ovf,
  input logic         irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!ovf && !irq)); // R1
  AST_RUN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_preload && run) |=> $stable(count)); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == pre)); // R4
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf); // R4
  AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ovf && ien)); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_preload) |=> $stable(count)); // R6
  AST_READ_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count && !wr_preload) |=> $stable(count)); // R9
endmodule

bind preload_timer preload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ien(ien), .rd_count(rd_count),
  .wr_preload(wr_preload), .count(count), .pre(pre), .ovf(ovf), .irq(irq)
);

// File: tb/preload_timer_tb.sv
module preload_timer_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_preload = 1'b0, wr_ctrl = 1'b0, rd_count = 1'b0;
  logic       ext_in = 1'b0, irq_ack = 1'b0;
  logic [7:0] wdata = '0, ctrl_data = '0;
  logic [7:0] count;
  logic       ovf, irq;
  int checks = 0, failures = 0;
  logic [7:0] c;

  always #5 clk = ~clk;

  preload_timer #(.W(8), .PSW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_preload(wr_preload), .wdata(wdata),
    .wr_ctrl(wr_ctrl), .ctrl_data(ctrl_data), .rd_count(rd_count),
    .count(count), .ext_in(ext_in), .irq_ack(irq_ack), .ovf(ovf), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wctrl(logic [7:0] d);
    wr_ctrl = 1'b1; ctrl_data = d; cyc(1); wr_ctrl = 1'b0;
  endtask

  task automatic wpre(logic [7:0] d);
    wr_preload = 1'b1; wdata = d; cyc(1); wr_preload = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 8'h00);
    chk("R1 ovf", {7'd0, ovf}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_timer;
    wpre(8'hF0);
    chk("R2 stopped load", count, 8'hF0);
    wctrl(8'h0A);
    cyc(5);
    chk("R3 timer ps0", count, 8'hF5);
    wctrl(8'h4A);
    c = count;
    cyc(8);
    chk("R3 timer ps2", count, c + 8'd2);
  endtask

  task automatic t_inhibit;
    wctrl(8'h0A);
    c = count;
    rd_count = 1'b1; cyc(4); rd_count = 1'b0;
    chk("R9 read inhibit", count, c);
    cyc(1);
    chk("R9 resume", count, c + 8'd1);
    c = count;
    wpre(8'h10);
    chk("R2 running write no load", count, c);
    cyc(1);
    chk("R9 resume after write", count, c + 8'd1);
  endtask

  task automatic t_freeze;
    wctrl(8'h02);
    c = count;
    cyc(10);
    chk("R6 enable off", count, c);
    wctrl(8'h08);
    cyc(10);
    chk("R6 mode stopped", count, c);
  endtask

  task automatic t_overflow;
    wpre(8'hFE);
    wctrl(8'h1A);
    cyc(1);
    chk("R4 at max", count, 8'hFF);
    chk("R4 no ovf yet", {7'd0, ovf}, 8'h00);
    cyc(1);
    chk("R4 reload", count, 8'hFE);
    chk("R4 ovf pulse", {7'd0, ovf}, 8'h01);
    chk("R5 irq set", {7'd0, irq}, 8'h01);
    cyc(1);
    chk("R4 ovf one cycle", {7'd0, ovf}, 8'h00);
    wctrl(8'h10);
    chk("R5 irq held", {7'd0, irq}, 8'h01);
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    chk("R5 irq ack", {7'd0, irq}, 8'h00);
    wpre(8'hFE);
    wctrl(8'h0A);
    cyc(2);
    chk("R5 masked ovf", {7'd0, ovf}, 8'h01);
    chk("R5 masked irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_event;
    wctrl(8'h00);
    wpre(8'h00);
    ext_in = 1'b0;
    wctrl(8'h09);
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; cyc(3); ext_in = 1'b0; cyc(3);
    end
    cyc(4);
    chk("R7 rising count", count, 8'd5);
    ext_in = 1'b1; cyc(2);
    chk("R7 latency before", count, 8'd5);
    cyc(1);
    chk("R7 latency third edge", count, 8'd6);
    ext_in = 1'b0; cyc(5);
    wctrl(8'h0D);
    ext_in = 1'b1; cyc(6);
    chk("R7 falling ignores rise", count, 8'd6);
    ext_in = 1'b0; cyc(6);
    chk("R7 falling counts fall", count, 8'd7);
  endtask

  task automatic t_pulse;
    wctrl(8'h00);
    wpre(8'h00);
    ext_in = 1'b0; cyc(4);
    wctrl(8'h0B);
    ext_in = 1'b1; cyc(10); ext_in = 1'b0; cyc(6);
    chk("R8 high width", count, 8'd10);
    wctrl(8'h00);
    wpre(8'h00);
    ext_in = 1'b1; cyc(4);
    wctrl(8'h0F);
    ext_in = 1'b0; cyc(7); ext_in = 1'b1; cyc(6);
    chk("R8 low width", count, 8'd7);
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_timer();
    t_inhibit();
    t_freeze();
    t_overflow();
    t_event();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule